// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Host Loading

This block holds a table of 24-bit colours indexed by pixel code, and lets a host fill it through a two-register, 32-bit write window. The host first writes a starting entry number to the index register. It then writes the colour register three times, giving red, then green, then blue. Each component comes from the most significant byte of the written word. Once blue has been written, the entry number moves to the next entry. The host can therefore load a run of consecutive entries without writing the index again.

A separate lookup port serves the pixel pipeline. It takes an entry number and returns the stored colour combinationally. Any table write can be seen on that port from the cycle after the write. Host reads of the window always return zero. The block runs on one clock and uses a synchronous active-low reset. Host writes are single-cycle strobes with no wait states.

Top module: `pal_dac_loader`

## Requirements
- R1: A write at byte offset 0 loads the current entry number from the low IDX_W bits of write-data bits 31:24, and the next colour write becomes a red write. Upper bits of that byte are ignored when IDX_W is less than 8.
- R2: Writes at byte offset 4 store write-data bits 31:24 into the current entry in the fixed order red, green, blue.
- R3: A colour write changes only the one component it targets in the current entry. The other two components of that entry, and all other entries, keep their values.
- R4: The blue write advances the entry number by one, wrapping from the last entry to entry 0, and the following colour write becomes a red write again.
- R5: An index write made part-way through a triple abandons that triple, so the next colour write is a red write to the newly loaded entry.
- R6: Writes at any offset other than 0 and 4 (for example 1, 2, 3, 8, 12) change neither the table, the entry number, nor the component position.
- R7: `host_rdata` is zero at all times.
- R8: After reset, every entry is black (0x000000) except the last entry, which is white (0xFFFFFF). The entry number is 0 and the next colour write is a red write.
- R9: `pix_rgb` presents {red[23:16], green[15:8], blue[7:0]} of entry `pix_idx` combinationally. A table write becomes visible there on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W (4) | Byte offset within the window |
| host_wdata | input | BUS_W (32) | Host write data |
| host_rdata | output | BUS_W (32) | Host read data, always zero |
| pix_idx | input | IDX_W (8) | Lookup entry number |
| pix_rgb | output | 24 | Colour of the looked-up entry |

## Verification
The bench builds the block with IDX_W = 4, which gives a 16-entry table. With this size, every entry can be read back after reset and after each loading pattern. A full run of 16 triples, plus one more triple, drives the entry number across its wrap point. Index bytes with set upper bits check that only the low IDX_W bits are taken. Interrupted triples, isolated component writes and writes at unused offsets are each followed by a sweep of the whole table, so any stray update is caught at the lookup port.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int COMP_W = 8;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;

  // Component position that follows a colour write.
  function automatic phase_e phase_after(input phase_e ph);
    case (ph)
      PH_RED:   phase_after = PH_GREEN;
      PH_GREEN: phase_after = PH_BLUE;
      default:  phase_after = PH_RED;
    endcase
  endfunction

  // One-hot component write enable: bit 2 red, bit 1 green, bit 0 blue.
  function automatic logic [2:0] lane_of(input phase_e ph);
    case (ph)
      PH_RED:   lane_of = 3'b100;
      PH_GREEN: lane_of = 3'b010;
      PH_BLUE:  lane_of = 3'b001;
      default:  lane_of = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pal_host_decode.sv
module pal_host_decode #(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32,
  parameter int OFS_INDEX = 0,
  parameter int OFS_COLOR = 4
) (
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic              wr_index,
  output logic              wr_color,
  output logic [7:0]        wr_byte,
  output logic [BUS_W-1:0]  host_rdata
);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFS_INDEX);
  localparam logic [ADDR_W-1:0] A_COLOR = ADDR_W'(OFS_COLOR);

  logic unused_low_bits;

  assign wr_index   = host_wr && (host_addr == A_INDEX);
  assign wr_color   = host_wr && (host_addr == A_COLOR);
  assign wr_byte    = host_wdata[BUS_W-1 -: 8];
  assign host_rdata = '0;
  assign unused_low_bits = ^host_wdata[BUS_W-9:0];
endmodule

// File: rtl/pal_sequencer.sv
module pal_sequencer
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_index,
  input  logic             wr_color,
  input  logic [7:0]       wr_byte,
  output logic [IDX_W-1:0] cur_idx,
  output phase_e           cur_phase,
  output logic [2:0]       comp_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      cur_phase <= PH_RED;
    end else if (wr_index) begin
      cur_idx   <= wr_byte[IDX_W-1:0];
      cur_phase <= PH_RED;
    end else if (wr_color) begin
      cur_phase <= phase_after(cur_phase);
      if (cur_phase == PH_BLUE) cur_idx <= cur_idx + 1'b1;
    end
  end

  assign comp_we = wr_color ? lane_of(cur_phase) : 3'b000;
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       comp_we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output rgb_t             rd_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  rgb_t table_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        table_q[i] <= (i == DEPTH-1) ? '1 : '0;
    end else begin
      if (comp_we[2]) table_q[wr_idx].r <= wr_byte;
      if (comp_we[1]) table_q[wr_idx].g <= wr_byte;
      if (comp_we[0]) table_q[wr_idx].b <= wr_byte;
    end
  end

  assign rd_rgb = table_q[rd_idx];
endmodule

// File: rtl/pal_dac_loader.sv
module pal_dac_loader
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [23:0]       pix_rgb
);
  // Named internal events, used by the bound checker.
  logic             wr_index;
  logic             wr_color;
  logic [7:0]       wr_byte;
  logic [IDX_W-1:0] cur_idx;
  phase_e           cur_phase;
  logic [2:0]       comp_we;
  rgb_t             rd_rgb;

  pal_host_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .wr_index(wr_index), .wr_color(wr_color), .wr_byte(wr_byte),
    .host_rdata(host_rdata)
  );

  pal_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_index(wr_index), .wr_color(wr_color),
    .wr_byte(wr_byte), .cur_idx(cur_idx), .cur_phase(cur_phase),
    .comp_we(comp_we)
  );

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .wr_idx(cur_idx),
    .wr_byte(wr_byte), .rd_idx(pix_idx), .rd_rgb(rd_rgb)
  );

  assign pix_rgb = rd_rgb;
endmodule

// File: rtl/pal_dac_loader_chk.sv
module pal_dac_loader_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int ADDR_W = 4,
  parameter int BUS_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [BUS_W-1:0]  host_wdata,
  input logic [BUS_W-1:0]  host_rdata,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [23:0]       pix_rgb,
  input logic              wr_index,
  input logic              wr_color,
  input logic [IDX_W-1:0]  cur_idx,
  input phase_e            cur_phase,
  input logic [2:0]        comp_we
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_index |=> (cur_idx == $past(host_wdata[BUS_W-8 +: IDX_W])) && (cur_phase == PH_RED));

  a_r2_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_color && !wr_index && cur_phase == PH_RED) |=> (cur_phase == PH_GREEN) && $stable(cur_idx));

  a_r2_green_then_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_color && !wr_index && cur_phase == PH_GREEN) |=> (cur_phase == PH_BLUE) && $stable(cur_idx));

  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_color && !wr_index && cur_phase == PH_BLUE) |=>
      (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == PH_RED));

  a_r6_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != ADDR_W'(0) && host_addr != ADDR_W'(4)) |=>
      $stable(cur_idx) && $stable(cur_phase));

  a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata == '0);

  a_r9_blue_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_we[0] && pix_idx == cur_idx) |=>
      (!$stable(pix_idx) || pix_rgb[7:0] == $past(host_wdata[BUS_W-1 -: 8])));
endmodule

bind pal_dac_loader pal_dac_loader_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_idx(pix_idx),
  .pix_rgb(pix_rgb), .wr_index(wr_index), .wr_color(wr_color),
  .cur_idx(cur_idx), .cur_phase(cur_phase), .comp_we(comp_we)
);

// File: tb/tb_pal_dac_loader.sv
module tb_pal_dac_loader;
  localparam int IW = 4;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [3:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic [IW-1:0] pix_idx = '0;
  logic [23:0]   pix_rgb;

  int checks = 0;
  int errors = 0;
  logic [23:0] model [N];
  int m_idx = 0;
  int m_ph  = 0;

  always #5 clk = ~clk;

  pal_dac_loader #(.IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  function automatic logic [7:0] shade(input int i, input int k);
    return 8'((i * 37 + k * 91 + 13) & 255);
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [7:0] top, input logic [23:0] low);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = {top, low};
    @(negedge clk);
    host_wr = 1'b0;
    // reference model from the requirements
    if (a == 4'd0) begin
      m_idx = int'(top) % N; m_ph = 0;
    end else if (a == 4'd4) begin
      case (m_ph)
        0: model[m_idx][23:16] = top;
        1: model[m_idx][15:8]  = top;
        default: model[m_idx][7:0] = top;
      endcase
      if (m_ph == 2) begin m_idx = (m_idx + 1) % N; m_ph = 0; end
      else m_ph = m_ph + 1;
    end
  endtask

  task automatic check_entry(input int i, input string req);
    pix_idx = IW'(i);
    #1;
    checks++;
    if (pix_rgb !== model[i]) begin
      errors++;
      $display("FAIL %s entry %0d actual %h expected %h", req, i, pix_rgb, model[i]);
    end
    checks++;
    if (host_rdata !== 32'd0) begin
      errors++;
      $display("FAIL R7 rdata actual %h expected 0", host_rdata);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) check_entry(i, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = (i == N-1) ? 24'hFFFFFF : 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset contents, last entry white
    sweep("R8");
    // R8: entry number 0 and red position after reset
    bus_write(4'd4, 8'h11, 24'h0);
    bus_write(4'd4, 8'h22, 24'h0);
    bus_write(4'd4, 8'h33, 24'h0);
    check_entry(0, "R8");
    // R1/R2: index byte upper bits ignored (0xA5 -> entry 5)
    bus_write(4'd0, 8'hA5, 24'hFFFFFF);
    bus_write(4'd4, 8'h81, 24'h123456);
    bus_write(4'd4, 8'h42, 24'h0);
    bus_write(4'd4, 8'hC3, 24'hABCDEF);
    check_entry(5, "R1");
    sweep("R2");
    // R3: lone red write keeps green/blue and neighbours; R9 seen next cycle
    bus_write(4'd0, 8'h07, 24'h0);
    bus_write(4'd4, 8'h5A, 24'h0);
    check_entry(7, "R9");
    sweep("R3");
    bus_write(4'd4, 8'h6B, 24'h0);
    sweep("R3");
    // R5: restart mid-triple
    bus_write(4'd0, 8'h03, 24'h0);
    bus_write(4'd4, 8'hE1, 24'h0);
    check_entry(3, "R5");
    sweep("R5");
    // R6: other offsets ignored, position kept (still at green of entry 3)
    for (int a = 1; a < 16; a++)
      if (a != 4) bus_write(4'(a), 8'hFF, 24'hFFFFFF);
    sweep("R6");
    bus_write(4'd4, 8'h9C, 24'h0);
    check_entry(3, "R6");
    // R4: full run of triples from entry 0 across the wrap
    bus_write(4'd0, 8'h00, 24'h0);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 3; k++) bus_write(4'd4, shade(i, k), 24'h0);
    sweep("R4");
    for (int k = 0; k < 3; k++) bus_write(4'd4, shade(99, k), 24'h0);
    check_entry(0, "R4");
    sweep("R4");
    // R9: combinational lookup follows pix_idx without a clock edge
    check_entry(N-1, "R9");
    check_entry(2, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule